// File: doc/BRIEF.md
# Four-Channel Shared-Timebase PWM Generator

This block makes four pulse-width-modulated outputs from one up-counter. The counter is clocked through a prescaler, and it wraps at an auto-reload limit. That limit sets the period for every channel at once. Each channel compares the shared count with its own compare value to set its duty. Each channel also has an enable, a polarity bit and a complementary output that can be switched on or off.

Software programs the block through a one-cycle write port. Prescaler and compare writes always go to shadow copies. A reload write can go either to a shadow copy or straight to the active register. Shadow copies move to the active registers when the counter wraps, or when software writes an update-event command. That command also clears the counter and the prescaler.

Control is a two-state machine held in the run register. ST_HALT freezes the count and idles every output. ST_COUNT advances the count. A control write with run=1 takes ST_HALT to ST_COUNT, and a control write with run=0 takes it back.

Top module: `qpwm_top`

## Requirements
- R1: Whenever the prescaler ticks in ST_COUNT, the counter steps up by one. A tick at a count of reload or more returns it to 0, so one period lasts reload+1 ticks.
- R2: The prescaler (address 1) gives one tick every prescaler+1 clocks. A new prescaler value is used only from the next counter wrap or update event.
- R3: Address 0 is the control word: bit0 run, bit1 reload preload, bit2 main output enable. With preload set, a reload write (address 2) takes effect at the next wrap or update event. With preload clear, it takes effect on the next clock.
- R4: A compare write (address 5+n for channel n) takes effect only at the next counter wrap or update event.
- R5: An enabled channel's main output, before polarity, is 1 while the count is below its active compare value and 0 otherwise.
- R6: A compare of 0 gives a constant 0 before polarity. A compare above the reload value gives a constant 1 before polarity.
- R7: A channel's polarity bit inverts both its main and its complementary output.
- R8: With its complementary-enable bit set, an active channel's complementary output is the inverse of its main output. With that bit clear, the complementary output stays at the idle level.
- R9: In the channel word (address 3), channel n uses bit 4n for enable, bit 4n+1 for polarity and bit 4n+2 for complementary enable. Bit 4n+3 has no effect.
- R10: While the main output enable is 0, every output sits at its idle level, which is the channel's polarity bit.
- R11: In ST_HALT the counter and prescaler hold their values and every output sits at idle. After reset the block is in ST_HALT with all outputs 0.
- R12: Writing bit0=1 to address 4 copies all shadows to the active registers and clears the counter and prescaler on that clock.
- R13: A channel whose enable bit is 0 drives both of its outputs to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | CNT_W | Write data |
| pwm_o | output | NCH | Main channel outputs |
| pwm_n_o | output | NCH | Complementary channel outputs |

## Verification
The main sweep covers three prescaler settings and five reload limits. In each configuration the four compares are zero, mid-range, equal to the reload and one past it, and the polarity and complementary-enable patterns rotate. Every cycle is compared with an arithmetic model of the count. This separates a wrong period or prescale count from a wrong compare edge, and a swapped nibble field from an inverted polarity. Directed phases then write the reload, compare and prescaler in the middle of a period, with preload both set and clear. They also clear the main output enable, disable channels, halt the counter, and issue an update event mid-count. These phases separate immediate updates from updates deferred to the next wrap.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;
    localparam int ADR_CTRL  = 0;
    localparam int ADR_PSC   = 1;
    localparam int ADR_RLD   = 2;
    localparam int ADR_CHAN  = 3;
    localparam int ADR_EVT   = 4;
    localparam int ADR_CMP0  = 5;

    typedef enum logic {ST_HALT = 1'b0, ST_COUNT = 1'b1} run_state_e;

    typedef struct packed {
        logic cen;
        logic pol;
        logic en;
    } chan_cfg_t;
endpackage

// File: rtl/qpwm_timebase.sv
module qpwm_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ug,
    input  logic [CNT_W-1:0] psc_act,
    input  logic [CNT_W-1:0] rld_act,
    output logic [CNT_W-1:0] cnt,
    output logic             tick,
    output logic             wrap
);
    logic [CNT_W-1:0] pre_q;

    assign tick = run && (pre_q == psc_act);
    assign wrap = tick && (cnt >= rld_act);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt   <= '0;
        end else if (ug) begin
            pre_q <= '0;
            cnt   <= '0;
        end else if (run) begin
            if (tick) begin
                pre_q <= '0;
                cnt   <= wrap ? '0 : cnt + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/qpwm_channel.sv
module qpwm_channel #(
    parameter int CNT_W = 16
) (
    input  logic                 gate,
    input  logic [CNT_W-1:0]     cnt,
    input  logic [CNT_W-1:0]     cmp,
    input  qpwm_pkg::chan_cfg_t  cfg,
    output logic                 out_p,
    output logic                 out_n
);
    logic ref_hi;
    logic live;

    always_comb begin
        ref_hi = (cnt < cmp);
        live   = gate && cfg.en;
        out_p  = live ? (ref_hi ^ cfg.pol) : cfg.pol;
        out_n  = (live && cfg.cen) ? (~ref_hi ^ cfg.pol) : cfg.pol;
    end
endmodule

// File: rtl/qpwm_top.sv
module qpwm_top #(
    parameter int CNT_W = 16,
    parameter int NCH   = 4,
    parameter int ADDR_W = $clog2(qpwm_pkg::ADR_CMP0 + NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NCH-1:0]    pwm_o,
    output logic [NCH-1:0]    pwm_n_o
);
    import qpwm_pkg::*;

    run_state_e state_q, state_d;
    logic       pre_q, moe_q, run;
    logic [CNT_W-1:0] psc_sh, psc_act, rld_sh, rld_act;
    logic [CNT_W-1:0] cmp_sh  [NCH];
    logic [CNT_W-1:0] cmp_act [NCH];
    chan_cfg_t        cfg_q   [NCH];
    logic [NCH-1:0]   pol_vec;
    logic [CNT_W-1:0] cnt_q;
    logic tick, wrap, ug, ctrl_wr, load_act;

    assign ctrl_wr  = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
    assign ug       = wr_en && (wr_addr == ADDR_W'(ADR_EVT)) && wr_data[0];
    assign load_act = ug || wrap;

    // state transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (ctrl_wr && wr_data[0])  state_d = ST_COUNT;
            ST_COUNT: if (ctrl_wr && !wr_data[0]) state_d = ST_HALT;
            default:  state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // state outputs
    always_comb begin
        run = 1'b0;
        unique case (state_q)
            ST_HALT:  run = 1'b0;
            ST_COUNT: run = 1'b1;
            default:  run = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q   <= 1'b0;
            moe_q   <= 1'b0;
            psc_sh  <= '0;
            psc_act <= '0;
            rld_sh  <= '1;
            rld_act <= '1;
        end else begin
            if (load_act) begin
                psc_act <= psc_sh;
                rld_act <= rld_sh;
            end
            if (ctrl_wr) begin
                pre_q <= wr_data[1];
                moe_q <= wr_data[2];
            end
            if (wr_en && wr_addr == ADDR_W'(ADR_PSC)) psc_sh <= wr_data;
            if (wr_en && wr_addr == ADDR_W'(ADR_RLD)) begin
                rld_sh <= wr_data;
                if (!pre_q) rld_act <= wr_data;
            end
        end
    end

    qpwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .run(run), .ug(ug),
        .psc_act(psc_act), .rld_act(rld_act),
        .cnt(cnt_q), .tick(tick), .wrap(wrap)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cmp_sh[n]  <= '0;
                cmp_act[n] <= '0;
                cfg_q[n]   <= '0;
            end else begin
                if (load_act) cmp_act[n] <= cmp_sh[n];
                if (wr_en && wr_addr == ADDR_W'(ADR_CMP0 + n)) cmp_sh[n] <= wr_data;
                if (wr_en && wr_addr == ADDR_W'(ADR_CHAN))
                    cfg_q[n] <= '{cen: wr_data[4*n+2], pol: wr_data[4*n+1], en: wr_data[4*n]};
            end
        end
        assign pol_vec[n] = cfg_q[n].pol;

        qpwm_channel #(.CNT_W(CNT_W)) u_ch (
            .gate(run && moe_q), .cnt(cnt_q), .cmp(cmp_act[n]), .cfg(cfg_q[n]),
            .out_p(pwm_o[n]), .out_n(pwm_n_o[n])
        );
    end
endmodule

// File: rtl/qpwm_checker.sv
module qpwm_checker #(
    parameter int CNT_W = 16,
    parameter int NCH   = 4,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  wr_data,
    input logic              run,
    input logic              moe,
    input logic              tick,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  rld,
    input logic [NCH-1:0]    pol,
    input logic [NCH-1:0]    pwm_o,
    input logic [NCH-1:0]    pwm_n_o
);
    logic ug_w;
    assign ug_w = wr_en && (wr_addr == ADDR_W'(qpwm_pkg::ADR_EVT)) && wr_data[0];

    a_r12_event_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ug_w |=> (cnt == '0));

    a_r11_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ug_w) |=> $stable(cnt));

    a_r1_wraps_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && (cnt >= rld) && !ug_w) |=> (cnt == '0));

    a_r10_idle_without_moe: assert property (@(posedge clk) disable iff (!rst_n)
        !moe |-> (pwm_o == pol && pwm_n_o == pol));

    a_r11_idle_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (pwm_o == pol && pwm_n_o == pol));
endmodule

bind qpwm_top qpwm_checker #(.CNT_W(CNT_W), .NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run(run), .moe(moe_q), .tick(tick), .cnt(cnt_q), .rld(rld_act), .pol(pol_vec),
    .pwm_o(pwm_o), .pwm_n_o(pwm_n_o)
);

// File: tb/sim_qpwm_top.sv
module sim_qpwm_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  pwm_o, pwm_n_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_req = "R11";

    // reference model state
    logic        m_run = 0, m_pre = 0, m_moe = 0;
    logic [15:0] m_cnt = 0, m_pc = 0, m_psc = 0, s_psc = 0;
    logic [15:0] m_rld = 16'hFFFF, s_rld = 16'hFFFF;
    logic [15:0] m_cmp [4];
    logic [15:0] s_cmp [4];
    logic [2:0]  m_cfg [4];

    always #5 clk = ~clk;

    qpwm_top u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                 .wr_data(wr_data), .pwm_o(pwm_o), .pwm_n_o(pwm_n_o));

    task automatic model_step(input logic we, input logic [3:0] a, input logic [15:0] d);
        logic ug, load;
        ug = we && a == 4 && d[0];
        load = 0;
        if (ug) begin
            m_cnt = 0; m_pc = 0; load = 1;
        end else if (m_run) begin
            if (m_pc == m_psc) begin
                m_pc = 0;
                if (m_cnt >= m_rld) begin m_cnt = 0; load = 1; end
                else m_cnt = m_cnt + 1;
            end else m_pc = m_pc + 1;
        end
        if (load) begin
            m_psc = s_psc; m_rld = s_rld;
            for (int n = 0; n < 4; n++) m_cmp[n] = s_cmp[n];
        end
        if (we) begin
            if (a == 1) s_psc = d;
            if (a == 2) begin s_rld = d; if (!m_pre) m_rld = d; end
            if (a == 3) for (int n = 0; n < 4; n++) m_cfg[n] = {d[4*n+2], d[4*n+1], d[4*n]};
            if (a == 0) begin m_run = d[0]; m_pre = d[1]; m_moe = d[2]; end
            if (a >= 5 && a <= 8) s_cmp[a-5] = d;
        end
    endtask

    task automatic check_outputs();
        logic [3:0] ep, en;
        for (int n = 0; n < 4; n++) begin
            logic live, r, pol;
            pol  = m_cfg[n][1];
            live = m_run && m_moe && m_cfg[n][0];
            r    = m_cnt < m_cmp[n];
            ep[n] = live ? (r ^ pol) : pol;
            en[n] = (live && m_cfg[n][2]) ? (~r ^ pol) : pol;
        end
        checks++;
        if (pwm_o !== ep || pwm_n_o !== en) begin
            errors++;
            $display("FAIL %s cnt=%0d actual p=%b n=%b expected p=%b n=%b",
                     cur_req, m_cnt, pwm_o, pwm_n_o, ep, en);
        end
    endtask

    task automatic cyc(input logic we, input logic [3:0] a, input logic [15:0] d);
        wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        model_step(we, a, d);
        @(negedge clk);
        wr_en = 0;
        check_outputs();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0);
    endtask

    initial begin
        for (int n = 0; n < 4; n++) begin m_cmp[n] = 0; s_cmp[n] = 0; m_cfg[n] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R11"; check_outputs();           // reset state: all outputs 0

        // R1 R2 R5 R6 R7 R8 R9: sweep prescaler and reload
        for (int p = 0; p < 3; p++) begin
            for (int r = 0; r < 5; r++) begin
                logic [3:0] pol, cen;
                logic [15:0] cw;
                pol = 4'((p * 5 + r) & 15);
                cen = ~pol ^ 4'(r);
                cw = 0;
                for (int n = 0; n < 4; n++) begin
                    cw[4*n] = 1; cw[4*n+1] = pol[n]; cw[4*n+2] = cen[n]; cw[4*n+3] = r[0];
                end
                cur_req = "R9";
                cyc(1, 0, 16'b110);
                cyc(1, 1, 16'(p));
                cyc(1, 2, 16'(r));
                cyc(1, 5, 0);
                cyc(1, 6, 16'(r / 2 + 1));
                cyc(1, 7, 16'(r));
                cyc(1, 8, 16'(r + 1));
                cyc(1, 3, cw);
                cur_req = "R12"; cyc(1, 4, 1);
                cur_req = "R1";  cyc(1, 0, 16'b111);
                cur_req = "R5";  idle((r + 1) * (p + 1) * 3 + 2);
            end
        end

        // R3: reload preload on, then direct
        cur_req = "R3";
        cyc(1, 2, 6); idle(12);
        cyc(1, 0, 16'b101);                          // preload off
        idle(3);
        cyc(1, 2, 1); idle(8);
        cyc(1, 2, 5); idle(8);
        cyc(1, 0, 16'b111);

        // R4: compare write mid-period
        cur_req = "R4";
        cyc(1, 5, 3); idle(2); cyc(1, 6, 0); idle(14);

        // R2: prescaler change deferred
        cur_req = "R2";
        cyc(1, 1, 2); idle(30);
        cyc(1, 1, 0); idle(20);

        // R10: main output enable off
        cur_req = "R10";
        cyc(1, 0, 16'b011); idle(8);
        cyc(1, 0, 16'b111); idle(4);

        // R13: disable channels 1 and 3, keep polarity
        cur_req = "R13";
        cyc(1, 3, 16'h2725); idle(14);

        // R8: complementary enable off on all channels
        cur_req = "R8";
        cyc(1, 3, 16'h1313); idle(14);

        // R11: halt mid-count, counter holds
        cur_req = "R11";
        idle(3); cyc(1, 0, 16'b110); idle(10);
        cyc(1, 0, 16'b111); idle(6);

        // R12: update event mid-count
        cur_req = "R12";
        cyc(1, 5, 1); cyc(1, 2, 3); idle(2);
        cyc(1, 4, 1); idle(10);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule